// File: doc/BRIEF.md
# Four-Phase Handshake Button and LED Target

This block is a clocked target on a simple interlocked bus. The initiator places an address, a command and (for a write) data on the bus, then pulls an active-low request line low. The target decodes the request and answers only for its two locations: a push-button status bit that can be read, and a one-bit LED register that can be written. It signals completion by pulling an active-low acknowledge line low, and it releases acknowledge and its read data only after the initiator has raised request again. This gives a fully interlocked four-phase exchange.

The request line comes from another timing domain, so it passes through a two-flop synchroniser before the control logic sees it. Once a request is accepted, the target waits a parameterised number of clocks (`ACK_DELAY`, default 1) before it acknowledges. During a button read, the read data and its output enable are valid before acknowledge falls. During an LED write, the LED flop is updated before acknowledge falls. The data bus is split into an input from the initiator, an output from the target and an output-enable. Any tri-state driver sits outside this block.

Top module: `hs_io_target`

## Requirements
- R1: After reset, `ack_n` is 1, `rdata_oe` is 0, `rdata` is 0 and `led` is 0.
- R2: A read (`cmd` = 0) of address 0x04 drives `rdata_oe` = 1 and `rdata` = {7'b0, button}, where bit 0 is 1 when the button is pressed. The button level is sampled when the request is accepted.
- R3: A write (`cmd` = 1) to address 0x05 stores `wdata[0]` into the LED flop. `wdata` bits 7..1 are ignored.
- R4: For a button read, `rdata_oe` rises at the 3rd rising clock edge after `req_n` falls. `ack_n` stays 1 through edge 2+ACK_DELAY and falls at edge 3+ACK_DELAY, so the data is driven before acknowledge.
- R5: For an LED write, `led` takes its new value at the 3rd rising edge after `req_n` falls. This is before `ack_n` falls at edge 3+ACK_DELAY.
- R6: After `req_n` rises, `ack_n` stays 0 through the 2nd rising edge. At the 3rd edge, `ack_n` returns to 1 and `rdata_oe` returns to 0.
- R7: A request to any address other than 0x04 or 0x05 is never acknowledged, never drives `rdata_oe` and leaves `led` unchanged, however long `req_n` is held low.
- R8: A write to 0x04 or a read of 0x05 is acknowledged with the R4 timing. It leaves `led` unchanged and keeps `rdata_oe` at 0.
- R9: Whenever `rdata_oe` is 0, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 1 | Active-low request from the initiator, asynchronous |
| cmd | input | 1 | 0 = read, 1 = write |
| addr | input | 8 | Bus address |
| wdata | input | 8 | Write data from the initiator |
| rdata | output | 8 | Read data from the target |
| rdata_oe | output | 1 | Target is driving the data lines |
| ack_n | output | 1 | Active-low acknowledge |
| button | input | 1 | Push-button level, 1 = pressed |
| led | output | 1 | LED register output |

## Verification
Every result is counted in rising edges from the moment the bench moves `req_n`. Two edges go to the synchroniser. The third edge accepts the request, which sets the read enable and data or updates the LED. Acknowledge falls ACK_DELAY edges later, and the release lands on the third edge after `req_n` rises. The bench drives and samples on falling edges, and it checks each output both in the cycle just before its due edge and in the cycle just after it. The bench runs with a non-default delay so that the counter path is exercised. Unmapped addresses are held for several extra cycles to show that no acknowledge ever appears.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } hs_state_e;

  localparam logic CMD_READ  = 1'b0;
  localparam logic CMD_WRITE = 1'b1;

  // width of a counter able to hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int ACK_DELAY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,     // synchronised request, active low
  input  logic hit,       // address decodes to this target
  output logic accept,    // request taken this cycle
  output logic busy,      // a transaction is open
  output logic ack_n,
  output logic dly_done
);
  localparam int CW = cnt_width(ACK_DELAY);
  localparam logic [CW-1:0] LAST = CW'(ACK_DELAY - 1);

  hs_state_e state, state_nx;
  logic [CW-1:0] cnt;

  assign accept   = (state == ST_IDLE) && !req_s && hit;
  assign dly_done = (state == ST_WAIT) && (cnt == LAST);
  assign busy     = (state != ST_IDLE);
  assign ack_n    = (state != ST_DONE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept)   state_nx = ST_WAIT;
      ST_WAIT: if (dly_done) state_nx = ST_DONE;
      ST_DONE: if (req_s)    state_nx = ST_IDLE;
      default:               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_WAIT && !dly_done) cnt <= cnt + 1'b1;
      else                               cnt <= '0;
    end
  end

  // R4
  ack_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ack_n && busy);

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> $past(req_s));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && req_s) |=> ack_n);
endmodule

// File: rtl/hs_regs.sv
module hs_regs
  import hs_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BTN_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] LED_ADDR = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata_lsb,
  input  logic              button,
  output logic              hit,
  output logic              rd_btn_q,
  output logic              btn_q,
  output logic              led
);
  function automatic logic addr_hit(input logic [ADDR_W-1:0] a);
    return (a == BTN_ADDR) || (a == LED_ADDR);
  endfunction

  logic led_wr_ev;
  logic btn_rd_ev;

  assign hit       = addr_hit(addr);
  assign led_wr_ev = accept && (cmd == CMD_WRITE) && (addr == LED_ADDR);
  assign btn_rd_ev = accept && (cmd == CMD_READ)  && (addr == BTN_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led      <= 1'b0;
      rd_btn_q <= 1'b0;
      btn_q    <= 1'b0;
    end else begin
      if (led_wr_ev) led <= wdata_lsb;
      if (accept) begin
        rd_btn_q <= btn_rd_ev;
        btn_q    <= button;
      end
    end
  end

  // R3
  led_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led) |-> $past(led_wr_ev));
endmodule

// File: rtl/hs_io_target.sv
module hs_io_target
  import hs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ACK_DELAY   = 1,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BTN_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] LED_ADDR = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              ack_n,
  input  logic              button,
  output logic              led
);
  function automatic logic [DATA_W-1:0] btn_word(input logic b);
    return {{(DATA_W-1){1'b0}}, b};
  endfunction

  logic req_s, hit, accept, busy, dly_done, rd_btn_q, btn_q;
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:1];

  hs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(req_n), .q_sync(req_s)
  );

  hs_ctrl #(.ACK_DELAY(ACK_DELAY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .hit(hit),
    .accept(accept), .busy(busy), .ack_n(ack_n), .dly_done(dly_done)
  );

  hs_regs #(.ADDR_W(ADDR_W), .BTN_ADDR(BTN_ADDR), .LED_ADDR(LED_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd(cmd), .addr(addr),
    .wdata_lsb(wdata[0]), .button(button), .hit(hit),
    .rd_btn_q(rd_btn_q), .btn_q(btn_q), .led(led)
  );

  assign rdata_oe = busy && rd_btn_q;
  assign rdata    = rdata_oe ? btn_word(btn_q) : '0;

  // R4
  data_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_n) && rdata_oe) |-> $past(rdata_oe));

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata_oe) |-> $past(req_s));

  // R4
  ack_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(dly_done));
endmodule

// File: tb/test_hs_io_target.sv
module test_hs_io_target;
  localparam int DLY = 2;

  logic clk = 1'b0, rst_n = 1'b0, req_n = 1'b1, cmd = 1'b0, button = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic rdata_oe, ack_n, led;

  int n_run = 0, n_fail = 0;
  bit led_model = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hs_io_target #(.ACK_DELAY(DLY)) i_hs_io_target (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cmd(cmd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .ack_n(ack_n),
    .button(button), .led(led)
  );

  function automatic bit is_mapped(logic [7:0] a);
    return (a == 8'h04) || (a == 8'h05);
  endfunction

  function automatic logic [7:0] exp_read(bit b);
    return {7'b0, b};
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic txn(bit c, logic [7:0] a, logic [7:0] d, bit b);
    bit mapped = is_mapped(a);
    bit rdb = (c == 1'b0) && (a == 8'h04);
    bit ledw = (c == 1'b1) && (a == 8'h05);
    @(negedge clk);
    button = b; cmd = c; addr = a; wdata = d; req_n = 1'b0;
    for (int k = 1; k <= DLY + 3; k++) begin
      @(negedge clk);
      if (k == 2) chk(rdata_oe == 1'b0, "R4 oe early", rdata_oe, 0);
      if (k == 3) begin
        if (rdb) begin
          chk(rdata_oe == 1'b1, "R4 oe", rdata_oe, 1);
          chk(rdata == exp_read(b), "R2 rdata", rdata, exp_read(b));
        end else begin
          chk(rdata_oe == 1'b0, "R8 R7 oe", rdata_oe, 0);
          chk(rdata == 8'h00, "R9 rdata", rdata, 0);
        end
        if (ledw) chk(led == d[0], "R5 R3 led", led, d[0]);
      end
      if (k == DLY + 2) chk(ack_n == 1'b1, "R4 ack early", ack_n, 1);
    end
    chk(ack_n == !mapped, mapped ? "R4 ack" : "R7 ack", ack_n, !mapped);
    if (!ledw) chk(led == led_model, "R8 R7 led kept", led, led_model);
    if (rdb) chk(rdata == exp_read(b), "R2 rdata at ack", rdata, exp_read(b));
    if (!mapped) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(ack_n && !rdata_oe, "R7 no response", {ack_n, rdata_oe}, 2'b10);
      end
    end
    if (ledw) led_model = d[0];
    req_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k == 2 && mapped) chk(ack_n == 1'b0, "R6 ack held", ack_n, 0);
      if (k == 3) begin
        chk(ack_n == 1'b1, "R6 ack released", ack_n, 1);
        chk(rdata_oe == 1'b0, "R6 oe released", rdata_oe, 0);
        chk(rdata == 8'h00, "R9 rdata idle", rdata, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd373));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ack_n == 1'b1, "R1 ack", ack_n, 1);
    chk(rdata_oe == 1'b0, "R1 oe", rdata_oe, 0);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    chk(led == 1'b0, "R1 led", led, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    txn(1'b0, 8'h04, 8'h00, 1'b1);   // R2 pressed
    txn(1'b0, 8'h04, 8'h00, 1'b0);   // R2 released
    txn(1'b1, 8'h05, 8'hFE, 1'b0);   // R3 upper bits ignored, led stays 0
    txn(1'b1, 8'h05, 8'h01, 1'b0);   // R3 set
    txn(1'b1, 8'h04, 8'h00, 1'b1);   // R8 write to button address
    txn(1'b0, 8'h05, 8'h00, 1'b1);   // R8 read of led address
    txn(1'b1, 8'h06, 8'h00, 1'b0);   // R7 unmapped write
    txn(1'b0, 8'h03, 8'h00, 1'b1);   // R7 unmapped read
    txn(1'b1, 8'h85, 8'h00, 1'b0);   // R7 alias-like address
    txn(1'b1, 8'h05, 8'h00, 1'b0);   // R3 clear

    for (int i = 0; i < 60; i++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 3);
      a = (sel == 0) ? 8'h04 : (sel == 1) ? 8'h05 : (sel == 2) ? 8'($urandom) : 8'h04;
      txn(1'($urandom), a, 8'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule